// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor that takes a 3-bit priority code. Each of the seven request levels has a pending bit. A one-cycle set pulse on a level raises its bit, and a one-cycle clear pulse drops it. The block drives the processor with a registered level code that always equals the highest pending level, or zero when nothing is pending.

Level 7 has a second source: a non-maskable trigger input. The trigger is edge-detected, so holding it high raises exactly one request. Three levels have a device behind them: level 7 (the non-maskable source), level 2 (the input device) and level 1 (the output device).

When the processor acknowledges a level, the block answers one cycle later. The answer is "autovector" for levels that have a device and "spurious" for every other level, including level 0. Acknowledging level 7 also retires the level-7 request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pending`, `ipl`, `resp_valid` and `resp_autovec` are all 0. `resp_valid` is 1 only in the cycle after a cycle with `ack_valid` high.
- R2: A pulse on `set_pulse[n-1]` makes `pending[n-1]` (level n) 1 after the next clock edge. A pulse on `clr_pulse[n-1]` makes it 0 after the next clock edge.
- R3: If `set_pulse[n-1]` and `clr_pulse[n-1]` are both high in the same cycle, `pending[n-1]` is 1 after that edge.
- R4: After a cycle with set pulses and no clear, `ipl` rises to the newly pending level if that level is above the current `ipl`. Otherwise `ipl` keeps its value. The update lands on the same edge as the pending bit.
- R5: After any cycle containing a clear, `ipl` equals the highest level still pending, scanned from 7 down to 1, or 0 if no level is pending.
- R6: A low-to-high change on `nmi_trig` sets `pending[6]` on that edge. A trigger held high raises no further request, even after `pending[6]` has been cleared. A trigger that is already high when reset is released counts as one change.
- R7: An acknowledge (`ack_valid`=1) with `ack_level` equal to 7, 2 or 1 gives `resp_valid`=1 and `resp_autovec`=1 in the next cycle.
- R8: An acknowledge with `ack_level` equal to 0, 3, 4, 5 or 6 gives `resp_valid`=1 and `resp_autovec`=0 (spurious) in the next cycle.
- R9: An acknowledge on level 7 clears `pending[6]` unless a set for level 7 arrives in the same cycle. Acknowledges on other levels leave `pending` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| set_pulse | input | 7 | Per-level set request; bit n-1 is level n |
| clr_pulse | input | 7 | Per-level clear request; bit n-1 is level n |
| nmi_trig | input | 1 | Non-maskable trigger, edge-detected onto level 7 |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| pending | output | 7 | Pending mask; bit n-1 is level n |
| ipl | output | 3 | Registered highest pending level, 0 when idle |
| resp_valid | output | 1 | Acknowledge response valid, one cycle after `ack_valid` |
| resp_autovec | output | 1 | 1 = autovector, 0 = spurious |

## Verification
The hardest case to reach from the ports is a non-maskable trigger that stays high after its request has been retired. In that state the edge detector must not re-arm, even though the level-7 bit has been cleared by a clear pulse or by an acknowledge. The stimulus reaches it in two ways. It keeps `nmi_trig` high across several rows while acknowledging level 7. It also holds the trigger high through a reset release and then clears level 7 with the trigger still high. A further row pulses set and clear on one level while clearing another, so that the top-down rescan and the set-wins rule act on the same edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  parameter int unsigned NUM_LVL = 7;
  localparam int unsigned LVL_W  = $clog2(NUM_LVL + 1);

  typedef logic [NUM_LVL-1:0] lvl_mask_t;
  typedef logic [LVL_W-1:0]   lvl_t;

  localparam lvl_t NMI_LVL = lvl_t'(7);
  localparam lvl_t IN_LVL  = lvl_t'(2);
  localparam lvl_t OUT_LVL = lvl_t'(1);
  localparam int unsigned NMI_BIT = NMI_LVL - 1;

  // highest set level in a mask, scanned from the top; 0 when empty
  function automatic lvl_t top_level(lvl_mask_t m);
    lvl_t r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (!found && m[i]) begin
        r = lvl_t'(i + 1);
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = trig & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_prio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lvl_mask_t set_i,
  input  lvl_mask_t clr_i,
  output lvl_mask_t pend_q,
  output lvl_mask_t pend_d
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
    logic en;
    always_comb begin
      en        = set_i[g] | clr_i[g];
      pend_d[g] = en ? set_i[g] : pend_q[g];   // set wins over clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pend_q[g] <= 1'b0;
      else if (en) pend_q[g] <= set_i[g];
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_prio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lvl_mask_t pend_q,
  input  lvl_mask_t pend_d,
  input  lvl_mask_t set_i,
  input  lvl_mask_t clr_i,
  output lvl_t      ipl_q
);
  logic      clr_any;
  lvl_mask_t fresh;
  lvl_t      cand;
  lvl_t      ipl_d;
  logic      ipl_en;

  always_comb begin
    clr_any = |clr_i;
    fresh   = set_i & ~pend_q;
    cand    = top_level(fresh);
    ipl_d   = ipl_q;
    ipl_en  = 1'b0;
    if (clr_any) begin
      ipl_d  = top_level(pend_d);
      ipl_en = 1'b1;
    end else if (cand > ipl_q) begin
      ipl_d  = cand;
      ipl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ipl_q <= '0;
    else if (ipl_en) ipl_q <= ipl_d;
  end
endmodule

// File: rtl/irq_ack_route.sv
module irq_ack_route
  import irq_prio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_valid,
  input  lvl_t ack_level,
  output logic nmi_ack,
  output logic resp_valid_q,
  output logic resp_auto_q
);
  logic has_dev;
  logic auto_d;

  always_comb begin
    has_dev = (ack_level == NMI_LVL) || (ack_level == IN_LVL) ||
              (ack_level == OUT_LVL);
    auto_d  = ack_valid & has_dev;
    nmi_ack = ack_valid & (ack_level == NMI_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_auto_q  <= 1'b0;
    end else begin
      resp_valid_q <= ack_valid;
      resp_auto_q  <= auto_d;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [irq_prio_pkg::NUM_LVL-1:0]   set_pulse,
  input  logic [irq_prio_pkg::NUM_LVL-1:0]   clr_pulse,
  input  logic                               nmi_trig,
  input  logic                               ack_valid,
  input  logic [irq_prio_pkg::LVL_W-1:0]     ack_level,
  output logic [irq_prio_pkg::NUM_LVL-1:0]   pending,
  output logic [irq_prio_pkg::LVL_W-1:0]     ipl,
  output logic                               resp_valid,
  output logic                               resp_autovec
);
  import irq_prio_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       nmi_rise;
  logic       nmi_ack;
  lvl_mask_t  set_eff;
  lvl_mask_t  clr_eff;
  lvl_mask_t  pend_q;
  lvl_mask_t  pend_d;
  lvl_t       ipl_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_edge_det u_nmi_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .trig  (nmi_trig),
    .rise  (nmi_rise)
  );

  irq_ack_route u_ack (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ack_valid    (ack_valid),
    .ack_level    (ack_level),
    .nmi_ack      (nmi_ack),
    .resp_valid_q (resp_valid),
    .resp_auto_q  (resp_autovec)
  );

  always_comb begin
    set_eff          = set_pulse;
    clr_eff          = clr_pulse;
    set_eff[NMI_BIT] = set_pulse[NMI_BIT] | nmi_rise;
    clr_eff[NMI_BIT] = clr_pulse[NMI_BIT] | nmi_ack;
  end

  irq_pend_bank u_pend (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (set_eff),
    .clr_i  (clr_eff),
    .pend_q (pend_q),
    .pend_d (pend_d)
  );

  irq_level_track u_lvl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pend_q (pend_q),
    .pend_d (pend_d),
    .set_i  (set_eff),
    .clr_i  (clr_eff),
    .ipl_q  (ipl_q)
  );

  assign pending = pend_q;
  assign ipl     = ipl_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input lvl_mask_t set_pulse,
  input lvl_mask_t clr_pulse,
  input logic      nmi_trig,
  input logic      ack_valid,
  input lvl_t      ack_level,
  input lvl_mask_t pending,
  input lvl_t      ipl,
  input logic      resp_valid,
  input logic      resp_autovec
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R4 R5
  ipl_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipl == top_level(pending));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |=> ((pending & $past(set_pulse)) == $past(set_pulse)));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_pulse & clr_pulse) != '0) |=>
      ((pending & $past(set_pulse & clr_pulse)) == $past(set_pulse & clr_pulse)));

  // R6
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && nmi_trig && $past(nmi_trig) && clr_pulse[NMI_BIT] &&
     !set_pulse[NMI_BIT]) |=> !pending[NMI_BIT]);

  // R7 R8
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (resp_valid && (resp_autovec ==
      ($past(ack_level) == 3'd7 || $past(ack_level) == 3'd2 ||
       $past(ack_level) == 3'd1))));

  // R1
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> (!resp_valid && !resp_autovec));

  // R9
  nmi_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level == NMI_LVL && !set_pulse[NMI_BIT] && !nmi_trig)
      |=> !pending[NMI_BIT]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .set_pulse    (set_pulse),
  .clr_pulse    (clr_pulse),
  .nmi_trig     (nmi_trig),
  .ack_valid    (ack_valid),
  .ack_level    (ack_level),
  .pending      (pending),
  .ipl          (ipl),
  .resp_valid   (resp_valid),
  .resp_autovec (resp_autovec)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic [6:0] set_pulse;
  logic [6:0] clr_pulse;
  logic       nmi_trig;
  logic       ack_valid;
  logic [2:0] ack_level;
  logic [6:0] pending;
  logic [2:0] ipl;
  logic       resp_valid;
  logic       resp_autovec;

  int checks;
  int fails;
  bit done;

  prio_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_pulse    (set_pulse),
    .clr_pulse    (clr_pulse),
    .nmi_trig     (nmi_trig),
    .ack_valid    (ack_valid),
    .ack_level    (ack_level),
    .pending      (pending),
    .ipl          (ipl),
    .resp_valid   (resp_valid),
    .resp_autovec (resp_autovec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: set[30:24] clr[23:17] nmi[16] ackv[15] acklvl[14:12]
  //         exp_pend[11:5] exp_ipl[4:2] exp_rv[1] exp_ra[0]
  localparam int NROW = 16;
  localparam logic [30:0] TBL [NROW] = '{
    31'b0000010_0000000_0_0_000_0000010_010_0_0, // R2 R4 set L2
    31'b0010000_0000000_0_0_000_0010010_101_0_0, // R4 set L5 raises
    31'b0000100_0000000_0_0_000_0010110_101_0_0, // R4 set L3 no raise
    31'b0000000_0010000_0_0_000_0000110_011_0_0, // R5 clear L5 rescans
    31'b0000000_0000000_0_1_010_0000110_011_1_1, // R7 R9 ack L2 autovec
    31'b0000000_0000000_0_1_011_0000110_011_1_0, // R8 ack L3 spurious
    31'b0100000_0100100_0_0_000_0100010_110_0_0, // R3 R5 set+clr L6, clr L3
    31'b0000000_0000000_1_0_000_1100010_111_0_0, // R6 nmi edge
    31'b0000000_0000000_1_1_111_0100010_110_1_1, // R9 R7 ack L7 held trig
    31'b0000000_0000000_1_0_000_0100010_110_0_0, // R6 held, no retrigger
    31'b0000000_0000000_0_1_000_0100010_110_1_0, // R8 ack L0 spurious
    31'b0000000_0000000_1_0_000_1100010_111_0_0, // R6 new edge
    31'b0000000_1111111_0_0_000_0000000_000_0_0, // R5 clear all
    31'b0000001_0000000_0_1_001_0000001_001_1_1, // R7 ack L1 autovec
    31'b1000000_0000001_0_1_110_1000000_111_1_0, // R5 R8 ack L6 spurious
    31'b0000000_0000000_0_0_000_1000000_111_0_0  // R1 no ack no resp
  };

  task automatic chk(input string req, input string what,
                     input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [30:0] r);
    set_pulse = r[30:24];
    clr_pulse = r[23:17];
    nmi_trig  = r[16];
    ack_valid = r[15];
    ack_level = r[14:12];
  endtask

  task automatic idle();
    set_pulse = '0;
    clr_pulse = '0;
    ack_valid = 1'b0;
    ack_level = '0;
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    idle();
    nmi_trig = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pending in reset", pending, 7'd0);
    chk("R1", "ipl in reset", {4'd0, ipl}, 7'd0);
    chk("R1", "resp in reset", {5'd0, resp_valid, resp_autovec}, 7'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pending after release", pending, 7'd0);

    // table walk
    drive(TBL[0]);
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      chk($sformatf("row%0d", i), "pending", pending, TBL[i][11:5]);
      chk($sformatf("row%0d", i), "ipl", {4'd0, ipl}, {4'd0, TBL[i][4:2]});
      chk($sformatf("row%0d", i), "resp", {5'd0, resp_valid, resp_autovec},
          {5'd0, TBL[i][1:0]});
      if (i + 1 < NROW) drive(TBL[i+1]);
      else begin idle(); nmi_trig = 1'b0; end
    end

    // R1 reset in the middle of activity
    set_pulse = 7'b0000110;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R1", "pending async reset", pending, 7'd0);
    chk("R1", "ipl async reset", {4'd0, ipl}, 7'd0);

    // R6 trigger held through reset release counts once
    nmi_trig = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6", "held trigger at release", pending, 7'b1000000);
    chk("R6", "ipl after release edge", {4'd0, ipl}, 7'd7);
    clr_pulse = 7'b1000000;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk("R6", "no retrigger while held", pending, 7'd0);
    chk("R5", "ipl after clear", {4'd0, ipl}, 7'd0);
    nmi_trig = 1'b0;
    @(negedge clk);
    nmi_trig = 1'b1;
    @(negedge clk);
    chk("R6", "fresh edge", pending, 7'b1000000);

    // R9 ack on L1 does not clear L1
    nmi_trig  = 1'b0;
    set_pulse = 7'b0000001;
    @(negedge clk);
    idle();
    ack_valid = 1'b1;
    ack_level = 3'd1;
    @(negedge clk);
    idle();
    chk("R9", "ack L1 keeps pending", pending, 7'b1000001);
    chk("R7", "ack L1 response", {5'd0, resp_valid, resp_autovec}, 7'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule